// File: doc/BRIEF.md
# Stuck-Code Sample Repair Filter

This block is a single-channel streaming filter for 12-bit digitizer samples. It handles a converter fault in which the six lowest output bits freeze at all-zeros or all-ones, whatever the input is. Each incoming sample whose low six-bit field reads exactly 0 or 63 is marked as suspect. The block holds a short look-ahead window so that it can see the next good sample before it releases a suspect one.

A short run of suspect samples is rewritten by linear interpolation. The line runs between the good sample just before the run and the good sample just after it. A run that is too long to repair is forwarded untouched and marked as unrepairable. Both sides use a valid/ready handshake. Every sample leaves in arrival order, exactly `RUN_MAX+1` accepted samples after it entered. The stream has no end-of-stream flush, so the last `RUN_MAX+1` samples stay in the window until more input pushes them out.

Top module: `sample_stuck_repair`

## Requirements
- R1: A sample is suspect exactly when bits [5:0] are 6'd0 or 6'd63. The upper bits [11:6] play no part in this test.
- R2: A sample that is not suspect leaves with its value unchanged and with `out_fixed` and `out_unrep` both low.
- R3: A single suspect sample between good samples a and b leaves as floor((a+b)/2), with `out_fixed` high.
- R4: A run of L suspect samples, 2 <= L <= RUN_MAX (default 3), lies between good samples a and b. Its p-th sample (p = 1..L) leaves as floor((a*(L+1-p) + b*p)/(L+1)), with `out_fixed` high.
- R5: Every sample of a run longer than RUN_MAX leaves with its value unchanged, `out_unrep` high and `out_fixed` low. `out_fixed` and `out_unrep` are never high together.
- R6: A run of at most RUN_MAX suspect samples that has no good sample before it leaves as copies of the next good sample, with `out_fixed` high.
- R7: Sample k is presented on the output only after sample k+RUN_MAX+1 has been accepted. Samples leave in input order, and nothing leaves during the first RUN_MAX+1 accepts.
- R8: While `out_valid` is high and `out_ready` is low, the output word and both flags hold steady. `in_ready` equals `!out_valid || out_ready`.
- R9: After reset, `out_valid` is low, `in_ready` is high, the window is empty and no good sample is remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Filter can take a sample this cycle |
| in_sample | input | 12 | Raw converter code |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes the output this cycle |
| out_sample | output | 12 | Passed or repaired code |
| out_fixed | output | 1 | Output value was interpolated or copied |
| out_unrep | output | 1 | Output is part of a run too long to repair |

## Verification
The assertions assume that the downstream side never drops a presented word. They also assume that the input code and `in_valid` are stable and known during any cycle in which a handshake can occur. The bench drives inputs only between edges and lowers `in_valid` once the prepared stream is used up. It places suspect runs of every length from 1 to RUN_MAX+2 at the stream start, between good samples and back to back. It also lets random good codes land on 0 or 63 by chance, while random gaps on both handshakes exercise the stall path.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
   typedef enum logic [1:0] {
      KIND_PASS  = 2'd0,
      KIND_FIXED = 2'd1,
      KIND_UNREP = 2'd2
   } ssr_kind_e;
endpackage

// File: rtl/ssr_classify.sv
module ssr_classify #(
   parameter int SAMPLE_W = 12,
   parameter int FIELD_W  = 6
) (
   input  logic [SAMPLE_W-1:0] smp,
   output logic                stuck
);
   logic [FIELD_W-1:0] low_field;
   assign low_field = smp[FIELD_W-1:0];
   // R1: all-zero or all-one low field marks a suspect code
   assign stuck = (low_field == '0) || (low_field == '1);
endmodule

// File: rtl/ssr_window.sv
module ssr_window #(
   parameter int SAMPLE_W = 12,
   parameter int DEPTH    = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           shift,
   input  logic [SAMPLE_W-1:0]            in_data,
   input  logic                           in_flag,
   output logic [DEPTH-1:0][SAMPLE_W-1:0] win_data,
   output logic [DEPTH-1:0]               win_flag
);
   // slot 0 is the oldest entry, slot DEPTH-1 the newest
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [SAMPLE_W-1:0] nxt_d;
      logic                nxt_f;
      if (g == DEPTH - 1) begin : g_tail
         assign nxt_d = in_data;
         assign nxt_f = in_flag;
      end else begin : g_body
         assign nxt_d = win_data[g+1];
         assign nxt_f = win_flag[g+1];
      end
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            win_data[g] <= '0;
            win_flag[g] <= 1'b0;
         end else if (shift) begin
            win_data[g] <= nxt_d;
            win_flag[g] <= nxt_f;
         end
      end
   end
endmodule

// File: rtl/ssr_interp.sv
module ssr_interp
   import ssr_pkg::*;
#(
   parameter int SAMPLE_W = 12,
   parameter int RUN_MAX  = 3
) (
   input  logic [RUN_MAX:0][SAMPLE_W-1:0]    win_data,
   input  logic [RUN_MAX:0]                  win_flag,
   input  logic [SAMPLE_W-1:0]               prev_good,
   input  logic                              have_good,
   input  logic [$clog2(RUN_MAX+2)-1:0]      prev_cnt,
   output logic [SAMPLE_W-1:0]               res_data,
   output logic [SAMPLE_W-1:0]               next_good,
   output ssr_kind_e                         kind
);
   localparam int CNT_W = $clog2(RUN_MAX + 2);
   localparam int LEN_W = $clog2(2 * RUN_MAX + 3);
   localparam int NUM_W = SAMPLE_W + LEN_W;

   logic [LEN_W-1:0]    fwd, run_len, pos;
   logic                open_run;
   logic [SAMPLE_W-1:0] interp_val;

   // count suspect samples directly after the oldest slot, pick the bounding good one
   always_comb begin
      fwd      = '0;
      open_run = 1'b1;
      for (int i = 1; i <= RUN_MAX; i++) begin
         if (open_run && win_flag[i]) fwd = fwd + LEN_W'(1);
         else                         open_run = 1'b0;
      end
      next_good = win_data[RUN_MAX];
      for (int i = RUN_MAX; i >= 1; i--) begin
         if (LEN_W'(i) == fwd + LEN_W'(1)) next_good = win_data[i];
      end
      pos     = LEN_W'(prev_cnt) + LEN_W'(1);
      run_len = pos + fwd;
   end

   if (RUN_MAX == 1) begin : g_avg_only
      logic [SAMPLE_W:0] sum;
      assign sum        = {1'b0, prev_good} + {1'b0, next_good};
      assign interp_val = sum[SAMPLE_W:1];
   end else begin : g_general
      logic [NUM_W-1:0] num, quo;
      always_comb begin
         num = NUM_W'(prev_good) * NUM_W'(run_len + LEN_W'(1) - pos)
             + NUM_W'(next_good) * NUM_W'(pos);
         quo = num / NUM_W'(run_len + LEN_W'(1));
      end
      assign interp_val = quo[SAMPLE_W-1:0];
   end

   always_comb begin
      kind     = KIND_PASS;
      res_data = win_data[0];
      if (win_flag[0]) begin
         if (fwd == LEN_W'(RUN_MAX) || run_len > LEN_W'(RUN_MAX)) begin
            kind = KIND_UNREP;
         end else begin
            kind     = KIND_FIXED;
            res_data = have_good ? interp_val : next_good;
         end
      end
   end
endmodule

// File: rtl/sample_stuck_repair.sv
module sample_stuck_repair
   import ssr_pkg::*;
#(
   parameter int SAMPLE_W = 12,
   parameter int FIELD_W  = 6,
   parameter int RUN_MAX  = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [SAMPLE_W-1:0] in_sample,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [SAMPLE_W-1:0] out_sample,
   output logic                out_fixed,
   output logic                out_unrep
);
   localparam int DEPTH  = RUN_MAX + 1;
   localparam int CNT_W  = $clog2(RUN_MAX + 2);
   localparam int FILL_W = $clog2(DEPTH + 1);

   if (FIELD_W < 1 || FIELD_W >= SAMPLE_W) begin : g_bad_field
      $error("FIELD_W must be between 1 and SAMPLE_W-1");
   end
   if (RUN_MAX < 1) begin : g_bad_run
      $error("RUN_MAX must be at least 1");
   end

   logic                           in_stuck, accept, full, emit;
   logic [FILL_W-1:0]              fill;
   logic [DEPTH-1:0][SAMPLE_W-1:0] win_data;
   logic [DEPTH-1:0]               win_flag;
   logic [SAMPLE_W-1:0]            prev_good, res_data, next_good;
   logic                           have_good;
   logic [CNT_W-1:0]               prev_cnt;
   ssr_kind_e                      kind;

   assign in_ready = !out_valid || out_ready;
   assign accept   = in_valid && in_ready;
   assign full     = (fill == FILL_W'(DEPTH));
   assign emit     = accept && full;

   ssr_classify #(.SAMPLE_W(SAMPLE_W), .FIELD_W(FIELD_W)) u_cls (
      .smp(in_sample), .stuck(in_stuck)
   );

   ssr_window #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_win (
      .clk(clk), .rst_n(rst_n), .shift(accept),
      .in_data(in_sample), .in_flag(in_stuck),
      .win_data(win_data), .win_flag(win_flag)
   );

   ssr_interp #(.SAMPLE_W(SAMPLE_W), .RUN_MAX(RUN_MAX)) u_fix (
      .win_data(win_data), .win_flag(win_flag),
      .prev_good(prev_good), .have_good(have_good), .prev_cnt(prev_cnt),
      .res_data(res_data), .next_good(next_good), .kind(kind)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill      <= '0;
         prev_good <= '0;
         have_good <= 1'b0;
         prev_cnt  <= '0;
      end else begin
         if (accept && !full) fill <= fill + FILL_W'(1);
         if (emit) begin
            if (win_flag[0]) begin
               if (prev_cnt != CNT_W'(RUN_MAX + 1)) prev_cnt <= prev_cnt + CNT_W'(1);
            end else begin
               prev_cnt  <= '0;
               prev_good <= win_data[0];
               have_good <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
         out_fixed  <= 1'b0;
         out_unrep  <= 1'b0;
      end else if (emit) begin
         out_valid  <= 1'b1;
         out_sample <= res_data;
         out_fixed  <= (kind == KIND_FIXED);
         out_unrep  <= (kind == KIND_UNREP);
      end else if (out_ready) begin
         out_valid  <= 1'b0;
      end
   end

   // R8: a stalled output word is held
   a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_sample)
                                  && $stable(out_fixed) && $stable(out_unrep));
   // R5: the two flags are exclusive
   a_r5_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_fixed && out_unrep));
   // R7: a new output appears only after a full window was shifted
   a_r7_fill_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(accept && full));
   // R2: a plain pass-through word never carries a suspect low field
   a_r2_pass_clean: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_fixed && !out_unrep |->
         (out_sample[FIELD_W-1:0] != '0) && (out_sample[FIELD_W-1:0] != '1));
   // R4: an interpolated value lies between its two bounding good samples
   a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      emit && kind == KIND_FIXED && have_good |->
         (res_data >= prev_good || res_data >= next_good) &&
         (res_data <= prev_good || res_data <= next_good));
   // R5: the run counter saturates just above the repair limit
   a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      prev_cnt <= CNT_W'(RUN_MAX + 1));
endmodule

// File: tb/sample_stuck_repair_test.sv
module sample_stuck_repair_test;
   localparam int CLK_PERIOD = 10;
   localparam int RUN        = 3;
   localparam int TOTAL      = 3000;
   localparam int LIMIT      = 150000;

   logic        clk = 1'b0;
   logic        rst_n, in_valid, in_ready, out_valid, out_ready, out_fixed, out_unrep;
   logic [11:0] in_sample, out_sample;

   int tests = 0, fails = 0;
   logic [11:0] xs    [TOTAL];
   logic [11:0] ev    [TOTAL];
   logic        efix  [TOTAL];
   logic        eunr  [TOTAL];
   string       etag  [TOTAL];

   always #(CLK_PERIOD/2) clk = ~clk;

   sample_stuck_repair #(.SAMPLE_W(12), .FIELD_W(6), .RUN_MAX(RUN)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_sample(in_sample), .out_valid(out_valid), .out_ready(out_ready),
      .out_sample(out_sample), .out_fixed(out_fixed), .out_unrep(out_unrep)
   );

   function automatic bit bad(input logic [11:0] v);
      return (v[5:0] == 6'd0) || (v[5:0] == 6'd63);
   endfunction

   function automatic logic [11:0] good_code();
      logic [11:0] v;
      v = 12'($urandom_range(0, 4095));
      while (bad(v)) v = 12'($urandom_range(0, 4095));
      return v;
   endfunction

   function automatic logic [11:0] stuck_code();
      logic [5:0] hi;
      hi = 6'($urandom_range(0, 63));
      return {hi, ($urandom_range(0, 1) == 1) ? 6'd63 : 6'd0};
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // expected output for every index, computed from the requirements
   task automatic build_expect();
      for (int k = 0; k < TOTAL; k++) begin
         ev[k] = xs[k]; efix[k] = 1'b0; eunr[k] = 1'b0; etag[k] = "R1 R2 pass";
         if (bad(xs[k])) begin
            int s, e, len, p, a, b;
            s = k; e = k;
            while (s > 0 && bad(xs[s-1])) s--;
            while (e < TOTAL - 1 && bad(xs[e+1])) e++;
            len = e - s + 1;
            if (len > RUN || e == TOTAL - 1) begin
               eunr[k] = 1'b1; etag[k] = "R5 unrepairable";
            end else begin
               efix[k] = 1'b1;
               b = int'(xs[e+1]);
               if (s == 0) begin
                  ev[k] = 12'(b); etag[k] = "R6 start copy";
               end else begin
                  a = int'(xs[s-1]); p = k - s + 1;
                  ev[k] = 12'((a * (len + 1 - p) + b * p) / (len + 1));
                  etag[k] = (len == 1) ? "R3 single" : "R4 run";
               end
            end
         end
      end
   endtask

   initial begin
      int idx, out_idx, acc_cnt, cyc;
      bit stall_pend;
      logic [11:0] st_d; logic st_f, st_u;
      void'($urandom(32'd4242));
      idx = 0;
      // directed prefix: start run, single, run of RUN, run of RUN+1, run of RUN+2
      xs[idx++] = 12'h140; xs[idx++] = 12'h27F; xs[idx++] = 12'h105;
      xs[idx++] = 12'h311; xs[idx++] = 12'h0C0; xs[idx++] = 12'h501;
      for (int i = 0; i < RUN; i++) xs[idx++] = stuck_code();
      xs[idx++] = 12'h0A5;
      for (int i = 0; i < RUN + 1; i++) xs[idx++] = stuck_code();
      xs[idx++] = 12'hF3E;
      for (int i = 0; i < RUN + 2; i++) xs[idx++] = stuck_code();
      xs[idx++] = 12'h002;
      while (idx < TOTAL) begin
         if ($urandom_range(0, 9) == 0) begin
            int n = $urandom_range(1, RUN + 2);
            for (int i = 0; i < n && idx < TOTAL; i++) xs[idx++] = stuck_code();
         end else begin
            xs[idx++] = ($urandom_range(0, 3) == 0) ? 12'($urandom_range(0, 4095)) : good_code();
         end
      end
      build_expect();

      rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; out_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
      check(in_ready == 1'b1, "R9 in_ready after reset", int'(in_ready), 1);

      idx = 0; out_idx = 0; acc_cnt = 0; cyc = 0; stall_pend = 0;
      while (out_idx < TOTAL - (RUN + 1)) begin
         @(negedge clk);
         cyc++;
         if (cyc > LIMIT) begin
            check(1'b0, "R7 watchdog expired", out_idx, TOTAL - (RUN + 1));
            break;
         end
         if (stall_pend) begin
            check(out_valid && out_sample == st_d && out_fixed == st_f && out_unrep == st_u,
                  "R8 stalled word held", int'(out_sample), int'(st_d));
            stall_pend = 0;
         end
         out_ready = ($urandom_range(0, 3) != 0);
         in_valid  = (idx < TOTAL) && ($urandom_range(0, 4) != 0);
         in_sample = (idx < TOTAL) ? xs[idx] : 12'h000;
         #1;
         check(in_ready == (!out_valid || out_ready), "R8 in_ready rule",
               int'(in_ready), int'(!out_valid || out_ready));
         if (out_valid && out_ready) begin
            check(out_sample == ev[out_idx], etag[out_idx], int'(out_sample), int'(ev[out_idx]));
            check(out_fixed == efix[out_idx], etag[out_idx], int'(out_fixed), int'(efix[out_idx]));
            check(out_unrep == eunr[out_idx], etag[out_idx], int'(out_unrep), int'(eunr[out_idx]));
            check(acc_cnt >= out_idx + RUN + 2, "R7 latency", acc_cnt, out_idx + RUN + 2);
            out_idx++;
         end else if (out_valid) begin
            stall_pend = 1; st_d = out_sample; st_f = out_fixed; st_u = out_unrep;
         end
         if (in_valid && in_ready) begin
            idx++; acc_cnt++;
         end
      end
      in_valid = 1'b0;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule